// File: doc/BRIEF.md
# Composite NTSC Sample Synthesizer

This block produces a low-resolution composite colour video waveform as a stream of digital samples. It runs the line and field timing itself. Each sample is either a fixed level (sync tip, porch, blanking), a burst sample, or a picture sample. A video controller watches `pix_active` and `pix_row` and supplies a 4-bit palette index in the same cycle. The 2-bit sample code drives a small resistor DAC. The same codes are also turned into a 1-bit pulse-density stream for a faster single-pin output.

Colour is not computed with multipliers. A free-running subcarrier phase accumulator supplies a phase index. The palette index and that phase index address a small precomputed pattern table. Burst and picture samples both use the same phase index, so they stay locked to each other.

Two field structures are available. Progressive mode sends identical 262-line fields. Interlaced mode sends 525-line frames, and a half-length line moves between the end of the even field and the start of the odd field. A double-scan option keeps the interlaced sync structure but asks the controller for the same rows in both fields. Mode changes are taken only at a frame boundary.

Top module: `nts_composite`

## Requirements
- R1: While `rst` is high (synchronous, active high), `dac_code` is 1 (blank level), `pdm_bit` is 0 and `pix_active` is 0. The first cycle after release is sample 0 of line 0 of the even field, with subcarrier phase 0.
- R2: `dac_code` shows the sample class of the timing state two clock cycles earlier. On ordinary lines, samples 0 to H_SYNC-1 are sync tip (code 0). All samples that are not sync, burst or picture are at blank level (code 1).
- R3: Burst samples sit at H_BURST_START up to H_BURST_START+H_BURST_LEN-1 on full-length lines outside vertical sync. The phase index p is the top PH_BITS bits of an accumulator that adds PHASE_INC every cycle. A burst sample is code 2 when p is in the lower half of its range, and code 1 otherwise.
- R4: A picture sample for palette index c at phase p depends on the hue h = c[2:0] and the low level lo = 2 if c[3] is set, otherwise 1. If h = 0 the code is lo. Otherwise the code is 3 when (p+h) mod 4 < 2, and lo when it is not. `pix_idx` has no effect on any sample that is not a picture sample.
- R5: `pix_active` is high exactly on samples H_ACT_START up to H_ACT_END-1 of lines V_ACT_START up to V_ACT_START+V_ACT_LINES-1. These are the cycles in which `pix_idx` is used.
- R6: In progressive mode every field has FIELD_LINES full lines of H_TOTAL samples, and `field_odd` stays 0. Lines 0 to VS_LINES-1 are vertical sync lines: code 0 up to the line length minus H_SYNC, and code 1 for the rest of the line.
- R7: In interlaced mode the even field has FIELD_LINES full lines followed by a half line of H_TOTAL/2 samples. That half line carries a sync tip and then blank. The odd field starts with a half-length vertical sync line and is followed by FIELD_LINES full lines. `field_odd` alternates from field to field.
- R8: `frame_tick` is high only on sample 0 of line 0 of the even field. This is every field in progressive mode and every second field in interlaced mode, which is when displayed content may change.
- R9: While `pix_active` is high, `pix_row` is r = line - V_ACT_START in progressive and double-scan modes, and 2r+`field_odd` in true interlace. Otherwise it is 0.
- R10: `ilace_en` and `dbl_scan` are sampled during reset, and also at the boundary into an even field. A change at any other time has no effect until that boundary.
- R11: `pdm_bit` follows `dac_code` by one cycle. Any three consecutive `pdm_bit` samples whose source codes all equal c contain exactly c ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst | input | 1 | Synchronous active-high reset |
| ilace_en | input | 1 | Request interlaced field structure |
| dbl_scan | input | 1 | In interlace, repeat rows in both fields |
| pix_idx | input | COL_W | Palette index for the current picture sample |
| pix_active | output | 1 | Picture sample requested this cycle |
| pix_row | output | ROW_W | Source row the controller should read |
| field_odd | output | 1 | Odd field in progress |
| frame_tick | output | 1 | Start of frame, content update point |
| dac_code | output | 2 | Composite sample code for the resistor DAC |
| pdm_bit | output | 1 | Pulse-density form of the sample stream |

## Verification
A line counter that wraps in the wrong place changes where the sync tips fall. A mistimed half line shows up as a sync tip one line early or late. In either case the next sample that differs from the expected level makes the error visible, which is at most one line after the fault, and the length between `frame_tick` pulses changes too. A stale phase index or table read shows up as a wrong burst or colour code two cycles later. A drifting pulse-density accumulator breaks the ones count within three samples of a constant level. A mode latched at the wrong moment changes the length of the field then in progress.

// File: rtl/ntsc_pkg.sv
package ntsc_pkg;
  typedef enum logic [1:0] {SEG_SYNC, SEG_BLANK, SEG_BURST, SEG_ACT} seg_t;
  localparam int CODE_W = 2;
  localparam logic [CODE_W-1:0] LVL_SYNC  = 2'd0;
  localparam logic [CODE_W-1:0] LVL_BLANK = 2'd1;
  localparam logic [CODE_W-1:0] LVL_MID   = 2'd2;
  localparam logic [CODE_W-1:0] LVL_PEAK  = 2'd3;
endpackage

// File: rtl/nts_timing.sv
module nts_timing
  import ntsc_pkg::*;
#(
  parameter int H_TOTAL       = 7945,
  parameter int H_SYNC        = 588,
  parameter int H_BURST_START = 700,
  parameter int H_BURST_LEN   = 314,
  parameter int H_ACT_START   = 1350,
  parameter int H_ACT_END     = 7750,
  parameter int FIELD_LINES   = 262,
  parameter int VS_LINES      = 3,
  parameter int V_ACT_START   = 20,
  parameter int V_ACT_LINES   = 240,
  parameter int ROW_W         = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ilace_en,
  input  logic             dbl_scan,
  output seg_t             seg,
  output logic             pix_active,
  output logic [ROW_W-1:0] pix_row,
  output logic             field_odd,
  output logic             frame_tick
);
  localparam int HW   = $clog2(H_TOTAL + 1);
  localparam int LW   = $clog2(FIELD_LINES + 2);
  localparam int HALF = H_TOTAL / 2;

  logic [HW-1:0]    h, len;
  logic [LW-1:0]    line;
  logic             field, ilace_q, dbl_q;
  logic             half_line, h_end, l_end, nxt_field, vs, act_line;
  logic [ROW_W-1:0] r;

  always_comb begin
    half_line = ilace_q && ((!field && line == LW'(FIELD_LINES)) || (field && line == '0));
    len       = half_line ? HW'(HALF) : HW'(H_TOTAL);
    h_end     = (h == len - HW'(1));
    l_end     = (line == (ilace_q ? LW'(FIELD_LINES) : LW'(FIELD_LINES - 1)));
    nxt_field = ilace_q ? ~field : 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      h       <= '0;
      line    <= '0;
      field   <= 1'b0;
      ilace_q <= ilace_en;
      dbl_q   <= dbl_scan;
    end else if (h_end) begin
      h <= '0;
      if (l_end) begin
        line  <= '0;
        field <= nxt_field;
        if (!nxt_field) begin
          ilace_q <= ilace_en;
          dbl_q   <= dbl_scan;
        end
      end else begin
        line <= line + LW'(1);
      end
    end else begin
      h <= h + HW'(1);
    end
  end

  always_comb begin
    vs       = line < LW'(VS_LINES);
    act_line = (line >= LW'(V_ACT_START)) && (line < LW'(V_ACT_START + V_ACT_LINES));
    if (vs)                      seg = (h < len - HW'(H_SYNC)) ? SEG_SYNC : SEG_BLANK;
    else if (h < HW'(H_SYNC))    seg = SEG_SYNC;
    else if (half_line)          seg = SEG_BLANK;
    else if (h >= HW'(H_BURST_START) && h < HW'(H_BURST_START + H_BURST_LEN))
                                 seg = SEG_BURST;
    else if (act_line && h >= HW'(H_ACT_START) && h < HW'(H_ACT_END))
                                 seg = SEG_ACT;
    else                         seg = SEG_BLANK;
  end

  always_comb begin
    r          = ROW_W'(line - LW'(V_ACT_START));
    pix_active = (seg == SEG_ACT);
    if (!pix_active)            pix_row = '0;
    else if (ilace_q && !dbl_q) pix_row = {r[ROW_W-2:0], field};
    else                        pix_row = r;
    field_odd  = field;
    frame_tick = (h == '0) && (line == '0) && !field;
  end

  AST_PROG_EVEN: assert property (@(posedge clk) disable iff (rst)
    !ilace_q |-> !field); // R6
  AST_MODE_HOLD: assert property (@(posedge clk) disable iff (rst)
    !(h == '0 && line == '0 && !field) |-> ($stable(ilace_q) && $stable(dbl_q))); // R10
  AST_H_BOUND: assert property (@(posedge clk) disable iff (rst)
    h < len); // R7
endmodule

// File: rtl/nts_ptab.sv
module nts_ptab
  import ntsc_pkg::*;
#(
  parameter int COL_W   = 4,
  parameter int PH_BITS = 2
) (
  input  logic              clk,
  input  logic [COL_W-1:0]  col,
  input  logic [PH_BITS-1:0] ph,
  output logic [CODE_W-1:0] q
);
  localparam int DEPTH = 1 << (COL_W + PH_BITS);
  localparam int NPH   = 1 << PH_BITS;

  logic [CODE_W-1:0] rom [DEPTH];

  function automatic logic [CODE_W-1:0] patt(input int c, input int p);
    int hue;
    logic [CODE_W-1:0] lo;
    hue = c % (1 << (COL_W - 1));
    lo  = (((c >> (COL_W - 1)) & 1) != 0) ? LVL_MID : LVL_BLANK;
    if (hue == 0) return lo;
    return (((p + hue) % NPH) < (NPH / 2)) ? LVL_PEAK : lo;
  endfunction

  initial begin
    for (int a = 0; a < DEPTH; a++) rom[a] = patt(a / NPH, a % NPH);
  end

  always_ff @(posedge clk) q <= rom[{col, ph}];
endmodule

// File: rtl/nts_pdm.sv
module nts_pdm
  import ntsc_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [CODE_W-1:0] code,
  output logic              bit_o
);
  logic [1:0] acc;
  logic [2:0] sum;

  always_comb sum = {1'b0, acc} + {1'b0, code};

  always_ff @(posedge clk) begin
    if (rst) begin
      acc   <= '0;
      bit_o <= 1'b0;
    end else if (sum >= 3'd3) begin
      acc   <= 2'(sum - 3'd3);
      bit_o <= 1'b1;
    end else begin
      acc   <= sum[1:0];
      bit_o <= 1'b0;
    end
  end

  AST_ACC_RANGE: assert property (@(posedge clk) disable iff (rst)
    acc < 2'd3); // R11
endmodule

// File: rtl/nts_composite.sv
module nts_composite
  import ntsc_pkg::*;
#(
  parameter int H_TOTAL       = 7945,
  parameter int H_SYNC        = 588,
  parameter int H_BURST_START = 700,
  parameter int H_BURST_LEN   = 314,
  parameter int H_ACT_START   = 1350,
  parameter int H_ACT_END     = 7750,
  parameter int FIELD_LINES   = 262,
  parameter int VS_LINES      = 3,
  parameter int V_ACT_START   = 20,
  parameter int V_ACT_LINES   = 240,
  parameter int ROW_W         = 10,
  parameter int COL_W         = 4,
  parameter int PH_BITS       = 2,
  parameter int PHASE_W       = 32,
  parameter longint PHASE_INC = 122992210
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ilace_en,
  input  logic             dbl_scan,
  input  logic [COL_W-1:0] pix_idx,
  output logic             pix_active,
  output logic [ROW_W-1:0] pix_row,
  output logic             field_odd,
  output logic             frame_tick,
  output logic [1:0]       dac_code,
  output logic             pdm_bit
);
  seg_t               seg, seg_d;
  logic [PHASE_W-1:0] phase;
  logic [PH_BITS-1:0] pidx, pidx_d;
  logic [CODE_W-1:0]  tab_q;

  assign pidx = phase[PHASE_W-1 -: PH_BITS];

  nts_timing #(
    .H_TOTAL(H_TOTAL), .H_SYNC(H_SYNC), .H_BURST_START(H_BURST_START),
    .H_BURST_LEN(H_BURST_LEN), .H_ACT_START(H_ACT_START), .H_ACT_END(H_ACT_END),
    .FIELD_LINES(FIELD_LINES), .VS_LINES(VS_LINES), .V_ACT_START(V_ACT_START),
    .V_ACT_LINES(V_ACT_LINES), .ROW_W(ROW_W)
  ) u_tim (
    .clk(clk), .rst(rst), .ilace_en(ilace_en), .dbl_scan(dbl_scan),
    .seg(seg), .pix_active(pix_active), .pix_row(pix_row),
    .field_odd(field_odd), .frame_tick(frame_tick)
  );

  nts_ptab #(.COL_W(COL_W), .PH_BITS(PH_BITS)) u_tab (
    .clk(clk), .col(pix_idx), .ph(pidx), .q(tab_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      phase    <= '0;
      seg_d    <= SEG_BLANK;
      pidx_d   <= '0;
      dac_code <= LVL_BLANK;
    end else begin
      phase  <= phase + PHASE_W'(PHASE_INC);
      seg_d  <= seg;
      pidx_d <= pidx;
      case (seg_d)
        SEG_SYNC:  dac_code <= LVL_SYNC;
        SEG_BURST: dac_code <= pidx_d[PH_BITS-1] ? LVL_BLANK : LVL_MID;
        SEG_ACT:   dac_code <= tab_q;
        default:   dac_code <= LVL_BLANK;
      endcase
    end
  end

  nts_pdm u_pdm (.clk(clk), .rst(rst), .code(dac_code), .bit_o(pdm_bit));

  AST_NO_PEAK_IDLE: assert property (@(posedge clk) disable iff (rst)
    (seg_d != SEG_ACT) |=> (dac_code != LVL_PEAK)); // R4
  AST_SYNC_LEVEL: assert property (@(posedge clk) disable iff (rst)
    (seg_d == SEG_SYNC) |=> (dac_code == LVL_SYNC)); // R2
endmodule

// File: tb/sim_nts_composite.sv
`timescale 1ns/1ps
module sim_nts_composite;
  localparam int HT = 64, HS = 5, BS = 7, BL = 8, AS = 20, AE = 60;
  localparam int FL = 262, VSL = 3, VAS = 20, VAL = 240;

  logic clk = 1'b0, rst = 1'b1, ilace_en = 1'b0, dbl_scan = 1'b0;
  logic [3:0] pix_idx = '0;
  logic pix_active, field_odd, frame_tick, pdm_bit;
  logic [9:0] pix_row;
  logic [1:0] dac_code;

  nts_composite #(
    .H_TOTAL(HT), .H_SYNC(HS), .H_BURST_START(BS), .H_BURST_LEN(BL),
    .H_ACT_START(AS), .H_ACT_END(AE), .FIELD_LINES(FL), .VS_LINES(VSL),
    .V_ACT_START(VAS), .V_ACT_LINES(VAL), .ROW_W(10), .COL_W(4), .PH_BITS(2),
    .PHASE_W(32), .PHASE_INC(64'd1073741824)
  ) u0 (
    .clk(clk), .rst(rst), .ilace_en(ilace_en), .dbl_scan(dbl_scan),
    .pix_idx(pix_idx), .pix_active(pix_active), .pix_row(pix_row),
    .field_odd(field_odd), .frame_tick(frame_tick), .dac_code(dac_code),
    .pdm_bit(pdm_bit)
  );

  always #2 clk = ~clk;

  int errors = 0, checks = 0, k = 0;
  int mh, mline, mfield, milace, mdbl;
  int eh [0:5];
  string tg [0:5];
  bit vh [0:5];
  bit pd1, pd2, done = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp, input string what);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d at sample %0d", tag, what, act, exp, k);
    end
  endtask

  function automatic int patt(input int c, input int p);
    int hue, lo;
    hue = c % 8;
    lo  = (c >= 8) ? 2 : 1;
    if (hue == 0) return lo;
    return (((p + hue) % 4) < 2) ? 3 : lo;
  endfunction

  function automatic bit is_half();
    return milace != 0 && ((mfield == 0 && mline == FL) || (mfield == 1 && mline == 0));
  endfunction

  task automatic expect_now(output int code, output string tag, output bit act);
    int len, p;
    len = is_half() ? HT / 2 : HT;
    p = k % 4;
    act = 0;
    if (mline < VSL) begin
      code = (mh < len - HS) ? 0 : 1; tag = (len == HT) ? "R6" : "R7";
    end else if (mh < HS) begin
      code = 0; tag = "R2";
    end else if (is_half()) begin
      code = 1; tag = "R7";
    end else if (mh >= BS && mh < BS + BL) begin
      code = (p < 2) ? 2 : 1; tag = "R3";
    end else if (mline >= VAS && mline < VAS + VAL && mh >= AS && mh < AE) begin
      code = patt(int'(pix_idx), p); tag = "R4"; act = 1;
    end else begin
      code = 1; tag = "R2";
    end
  endtask

  task automatic step_model();
    int len;
    len = is_half() ? HT / 2 : HT;
    if (mh == len - 1) begin
      mh = 0;
      if (mline == (milace != 0 ? FL : FL - 1)) begin
        mline = 0;
        mfield = (milace != 0) ? 1 - mfield : 0;
        if (mfield == 0) begin milace = int'(ilace_en); mdbl = int'(dbl_scan); end
      end else mline++;
    end else mh++;
  endtask

  task automatic one_cycle();
    int code, row;
    string tag;
    bit act;
    pix_idx = 4'((k * 5) ^ (k >> 3));
    #1;
    for (int i = 5; i > 0; i--) begin eh[i] = eh[i-1]; tg[i] = tg[i-1]; vh[i] = vh[i-1]; end
    expect_now(code, tag, act);
    eh[0] = code; tg[0] = tag; vh[0] = 1;
    chk(pix_active == act, "R5", int'(pix_active), int'(act), "pix_active");
    row = !act ? 0 : ((milace != 0 && mdbl == 0) ? 2 * (mline - VAS) + mfield : mline - VAS);
    chk(int'(pix_row) == row, "R9", int'(pix_row), row, "pix_row");
    chk(int'(field_odd) == mfield, "R7", int'(field_odd), mfield, "field_odd");
    chk(frame_tick == (mh == 0 && mline == 0 && mfield == 0), "R8", int'(frame_tick),
        int'(mh == 0 && mline == 0 && mfield == 0), "frame_tick");
    if (vh[2]) chk(int'(dac_code) == eh[2], tg[2], int'(dac_code), eh[2], "dac_code");
    if (vh[5] && eh[3] == eh[4] && eh[4] == eh[5])
      chk(int'(pdm_bit) + int'(pd1) + int'(pd2) == eh[3], "R11",
          int'(pdm_bit) + int'(pd1) + int'(pd2), eh[3], "pdm ones in 3");
    pd2 = pd1; pd1 = pdm_bit;
    @(posedge clk);
    step_model();
    @(negedge clk);
    k++;
  endtask

  task automatic run(input int n);
    for (int i = 0; i < n; i++) one_cycle();
  endtask

  task automatic do_reset(input bit il, input bit db);
    @(negedge clk);
    rst = 1'b1; ilace_en = il; dbl_scan = db;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(dac_code == 2'd1, "R1", int'(dac_code), 1, "dac_code in reset");
    chk(pdm_bit == 1'b0, "R1", int'(pdm_bit), 0, "pdm_bit in reset");
    chk(pix_active == 1'b0, "R1", int'(pix_active), 0, "pix_active in reset");
    rst = 1'b0;
    k = 0; mh = 0; mline = 0; mfield = 0; milace = int'(il); mdbl = int'(db);
    for (int i = 0; i < 6; i++) vh[i] = 0;
    pd1 = 0; pd2 = 0;
  endtask

  task automatic test_prog_then_switch();
    do_reset(1'b0, 1'b0);
    chk(frame_tick == 1'b1, "R1", int'(frame_tick), 1, "first sample is frame start");
    run(100 * HT);
    ilace_en = 1'b1;  // R10: request mid-field, must wait for boundary
    run(FL * HT - 100 * HT);
    chk(frame_tick == 1'b1, "R10", int'(frame_tick), 1, "progressive field kept 262 lines");
    chk(field_odd == 1'b0, "R6", int'(field_odd), 0, "even field after progressive");
    run(FL * HT + HT / 2);
    chk(field_odd == 1'b1, "R7", int'(field_odd), 1, "odd field after 262.5 lines");
    chk(frame_tick == 1'b0, "R8", int'(frame_tick), 0, "no frame tick on odd field");
    run(FL * HT + HT / 2);
    chk(frame_tick == 1'b1, "R8", int'(frame_tick), 1, "frame tick after 525 lines");
  endtask

  task automatic test_double_scan();
    do_reset(1'b1, 1'b1);
    run(FL * HT + HT / 2);
    chk(field_odd == 1'b1, "R7", int'(field_odd), 1, "double-scan odd field start");
    run(FL * HT + HT / 2);
    chk(frame_tick == 1'b1, "R8", int'(frame_tick), 1, "double-scan frame end");
    run(30 * HT);
  endtask

  initial begin
    test_prog_then_switch();
    test_double_scan();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (195000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog (all requirements) actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule